// File: doc/BRIEF.md
# Hierarchical indirect interrupt aggregator

This block collects up to 256 interrupt request lines, organised as 32 blocks of eight lines, with eight blocks under each of four master groups. Every line passes through a two-flop synchronizer. A per-line trigger setting then turns its activity into a pending latch. The trigger can be rising edge, falling edge, both edges, high level or low level. The pending latches are ORed upwards into block, master and root summaries, and a single summary interrupt goes to the host.

The host uses a plain register bus with a 16-bit address, an 8-bit write port and a combinational read port. Control pins are plain; there is no handshake, and a write takes effect on the clock edge where the write strobe is high. The host first reads the root register to find the pending masters, then reads a master register to find the pending blocks. It then writes the block number into the block-select register. After that, the latched register, the live register and the config register all refer to that block. One config byte carries the line number within the block, the trigger setting, and a clear request for that line's latch. The byte is guarded by a write-enable bit. A mask-and-acknowledge is a single config write with both mask bits and the clear bit set.

Top module: `hier_irq_agg`

## Requirements
- R1: After reset the summary interrupt is 0, every register reads 0, block select is 0, and every line is in edge mode with both mask bits set.
- R2: The root register at BASE+0 shows master n pending at bit n+1. Bit 0 and any bit above the last master read 0.
- R3: The master register at BASE+1+n holds a 1 at bit i exactly when block n*8+i has at least one pending line. Global line number = block*8 + bit.
- R4: BASE+5 holds block select (written value kept only when below 32, read back in bits 4:0). BASE+6 reads the 8 pending bits of the selected block. The config address and undecoded addresses read 0.
- R5: BASE+8 reads the synchronized live levels of the selected block. A line change driven before clock edge k is visible after edge k+1.
- R6: A write to BASE+7 changes configuration only when bit 7 is 1. Bits 6:4 select the line in the current block, bit 3 is clear, bit 2 masks rising, bit 1 masks falling, bit 0 selects level mode. A write with bit 7 at 0 has no effect.
- R7: In edge mode (bit 0 = 0), a synchronized rising transition sets the latch when bit 2 is 0, and a falling transition sets it when bit 1 is 0. For a line change before edge k, the latch shows after edge k+2.
- R8: In level mode (bit 0 = 1), bit 2 = 0 makes the line active high and bit 1 = 0 makes it active low. While the active level persists, the latch is set again on the cycle after a clear.
- R9: A config write with bit 3 set clears the addressed latch at that edge, and the clear wins over a set condition in the same cycle.
- R10: With both mask bits set, a line sets no new pending bit, and an existing pending bit stays until it is cleared.
- R11: The summary interrupt is 1 exactly when some pending latch is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 256 | Asynchronous interrupt request lines |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq_out | output | 1 | Summary interrupt to the host |

## Verification
The clear request and a detected trigger on the same line can fall in the same cycle, and the clear must win. The bench provokes this by toggling a rising-edge line and then issuing the clear write in the exact cycle when the synchronized edge reaches the detector, two cycles after the drive. It judges the result with a latched-status read on the next cycle, compared against the behavioural model. Level-mode lines that are held active meet the clear in the same way, and there the latch must come back one cycle later.

// File: rtl/hia_pkg.sv
package hia_pkg;
  localparam int LANES = 8;

  localparam int OFS_ROOT = 0;
  localparam int OFS_MST1 = 1;
  localparam int OFS_BSEL = 5;
  localparam int OFS_PEND = 6;
  localparam int OFS_CFG  = 7;
  localparam int OFS_LIVE = 8;

  localparam int CB_LVL = 0;
  localparam int CB_MFE = 1;
  localparam int CB_MRE = 2;
  localparam int CB_CLR = 3;
  localparam int CB_IDX = 4;
  localparam int CB_WE  = 7;

  typedef struct packed {
    logic lvl;
    logic mask_re;
    logic mask_fe;
  } trig_cfg_t;

  localparam trig_cfg_t TRIG_RST = '{lvl: 1'b0, mask_re: 1'b1, mask_fe: 1'b1};
endpackage

// File: rtl/hia_sync.sv
module hia_sync #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= din;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/hia_cell.sv
module hia_cell
  import hia_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cur,
  input  logic      prev,
  input  logic      cfg_we,
  input  trig_cfg_t cfg_word,
  input  logic      cfg_clr,
  output logic      pend
);
  trig_cfg_t cfg_q;
  logic      hit;

  always_comb begin
    if (cfg_q.lvl)
      hit = (!cfg_q.mask_re && cur) || (!cfg_q.mask_fe && !cur);
    else
      hit = (!cfg_q.mask_re && cur && !prev) || (!cfg_q.mask_fe && !cur && prev);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= TRIG_RST;
      pend  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_word;
      if (cfg_we && cfg_clr) pend <= 1'b0;
      else if (hit)          pend <= 1'b1;
    end
  end
endmodule

// File: rtl/hia_regs.sv
module hia_regs
  import hia_pkg::*;
#(
  parameter int                NUM_MASTERS = 4,
  parameter int                BLK_PER_M   = 8,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE        = 16'h01BB,
  localparam int NUM_BLK = NUM_MASTERS * BLK_PER_M,
  localparam int NUM_IN  = NUM_BLK * LANES,
  localparam int BSEL_W  = $clog2(NUM_BLK),
  localparam int IDX_W   = $clog2(NUM_IN),
  localparam int MSEL_W  = $clog2(NUM_MASTERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic [NUM_IN-1:0] pend_vec,
  input  logic [NUM_IN-1:0] live_vec,
  output logic [7:0]        bus_rdata,
  output logic              irq_out,
  output logic              cfg_hit,
  output logic [IDX_W-1:0]  cfg_idx,
  output trig_cfg_t         cfg_word,
  output logic              cfg_clr
);
  localparam logic [ADDR_W-1:0] A_ROOT = ADDR_W'(OFS_ROOT);
  localparam logic [ADDR_W-1:0] A_MST1 = ADDR_W'(OFS_MST1);
  localparam logic [ADDR_W-1:0] A_MEND = ADDR_W'(OFS_MST1 + NUM_MASTERS);
  localparam logic [ADDR_W-1:0] A_BSEL = ADDR_W'(OFS_BSEL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(OFS_LIVE);

  logic [ADDR_W-1:0]      ofs;
  logic [BSEL_W-1:0]      bsel;
  logic [MSEL_W-1:0]      msel;
  logic [NUM_BLK-1:0]     blk_any;
  logic [NUM_MASTERS-1:0] mst_any;

  assign ofs  = bus_addr - BASE;
  assign msel = MSEL_W'(ofs - A_MST1);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blk_any[b] = |pend_vec[b*LANES +: LANES];
  end
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    assign mst_any[m] = |blk_any[m*BLK_PER_M +: BLK_PER_M];
  end
  assign irq_out = |mst_any;

  always_ff @(posedge clk) begin
    if (!rst_n) bsel <= '0;
    else if (bus_wr && ofs == A_BSEL && int'(bus_wdata) < NUM_BLK)
      bsel <= bus_wdata[BSEL_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (ofs == A_ROOT)
      bus_rdata[NUM_MASTERS:1] = mst_any;
    else if (ofs >= A_MST1 && ofs < A_MEND)
      bus_rdata[BLK_PER_M-1:0] = blk_any[int'(msel)*BLK_PER_M +: BLK_PER_M];
    else if (ofs == A_BSEL)
      bus_rdata[BSEL_W-1:0] = bsel;
    else if (ofs == A_PEND)
      bus_rdata = pend_vec[int'(bsel)*LANES +: LANES];
    else if (ofs == A_LIVE)
      bus_rdata = live_vec[int'(bsel)*LANES +: LANES];
  end

  assign cfg_hit  = bus_wr && (ofs == A_CFG) && bus_wdata[CB_WE];
  assign cfg_idx  = {bsel, bus_wdata[CB_IDX +: 3]};
  assign cfg_word = '{lvl: bus_wdata[CB_LVL], mask_re: bus_wdata[CB_MRE],
                      mask_fe: bus_wdata[CB_MFE]};
  assign cfg_clr  = bus_wdata[CB_CLR];
endmodule

// File: rtl/hier_irq_agg.sv
module hier_irq_agg
  import hia_pkg::*;
#(
  parameter int                NUM_MASTERS = 4,
  parameter int                BLK_PER_M   = 8,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE        = 16'h01BB,
  localparam int NUM_IN = NUM_MASTERS * BLK_PER_M * LANES,
  localparam int IDX_W  = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_out
);
  logic [NUM_IN-1:0] cur_vec;
  logic [NUM_IN-1:0] prev_vec;
  logic [NUM_IN-1:0] pend_vec;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cfg_idx;
  trig_cfg_t         cfg_word;
  logic              cfg_clr;

  hia_sync #(.WIDTH(NUM_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .cur(cur_vec), .prev(prev_vec)
  );

  for (genvar j = 0; j < NUM_IN; j++) begin : g_cell
    hia_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .cur(cur_vec[j]), .prev(prev_vec[j]),
      .cfg_we(cfg_hit && (cfg_idx == IDX_W'(j))),
      .cfg_word(cfg_word), .cfg_clr(cfg_clr),
      .pend(pend_vec[j])
    );
  end

  hia_regs #(
    .NUM_MASTERS(NUM_MASTERS), .BLK_PER_M(BLK_PER_M),
    .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .pend_vec(pend_vec), .live_vec(cur_vec),
    .bus_rdata(bus_rdata), .irq_out(irq_out),
    .cfg_hit(cfg_hit), .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_clr(cfg_clr)
  );
endmodule

// File: rtl/hia_chk.sv
module hia_top_chk #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h01BB,
  parameter int                NUM_IN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              irq_out,
  input logic [NUM_IN-1:0] pend_vec
);
  assert_root_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == BASE) |-> (bus_rdata[0] == 1'b0));

  assert_summary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|pend_vec));
endmodule

module hia_cell_chk
  import hia_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cur,
  input logic      prev,
  input logic      cfg_we,
  input logic      cfg_clr,
  input trig_cfg_t cfg_q,
  input logic      pend
);
  assert_cfg_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  assert_edge_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !cfg_q.lvl && cur == prev && !cfg_we) |=> !pend);

  assert_level_reassert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.lvl && !cfg_q.mask_re && cur && !(cfg_we && cfg_clr)) |=> pend);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_clr) |=> !pend);

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mask_re && cfg_q.mask_fe && !pend) |=> !pend);
endmodule

bind hier_irq_agg hia_top_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_IN(NUM_IN)) u_top_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .pend_vec(pend_vec)
);

bind hia_cell hia_cell_chk u_cell_chk (
  .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev), .cfg_we(cfg_we),
  .cfg_clr(cfg_clr), .cfg_q(cfg_q), .pend(pend)
);

// File: tb/hier_irq_agg_bench.sv
`timescale 1ns/1ps
module hier_irq_agg_bench;
  localparam int          NI   = 256;
  localparam logic [15:0] BASE = 16'h01BB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [15:0]   bus_addr = BASE;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          irq_out;

  hier_irq_agg u_hier_irq_agg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  logic [NI-1:0] m_s1, m_cur, m_prev, m_pend, m_lvl, m_mre, m_mfe;
  int            m_bsel;
  logic [NI-1:0] in_reg = '0;
  int            n_vec = 0;
  int            n_bad = 0;
  string         phase = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_cur = '0; m_prev = '0; m_pend = '0;
      m_lvl = '0; m_mre = '1; m_mfe = '1; m_bsel = 0;
    end else begin
      logic [NI-1:0] nxt;
      nxt = m_pend;
      for (int j = 0; j < NI; j++) begin
        logic act;
        if (m_lvl[j]) act = (!m_mre[j] && m_cur[j]) || (!m_mfe[j] && !m_cur[j]);
        else act = (!m_mre[j] && m_cur[j] && !m_prev[j]) || (!m_mfe[j] && !m_cur[j] && m_prev[j]);
        if (act) nxt[j] = 1'b1;
      end
      if (bus_wr && bus_addr == BASE + 16'd7 && bus_wdata[7]) begin
        int k;
        k = m_bsel * 8 + int'(bus_wdata[6:4]);
        m_lvl[k] = bus_wdata[0];
        m_mfe[k] = bus_wdata[1];
        m_mre[k] = bus_wdata[2];
        if (bus_wdata[3]) nxt[k] = 1'b0;
      end
      if (bus_wr && bus_addr == BASE + 16'd5 && int'(bus_wdata) < 32) m_bsel = int'(bus_wdata);
      m_pend = nxt;
      m_prev = m_cur;
      m_cur  = m_s1;
      m_s1   = irq_in;
    end
  end

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    logic [7:0] r;
    int o;
    r = '0;
    o = int'(a - BASE);
    if (o == 0) begin
      for (int n = 0; n < 4; n++) r[n+1] = |m_pend[n*64 +: 64];
    end else if (o >= 1 && o <= 4) begin
      for (int i = 0; i < 8; i++) r[i] = |m_pend[((o-1)*8 + i)*8 +: 8];
    end else if (o == 5) r = 8'(m_bsel);
    else if (o == 6) r = m_pend[m_bsel*8 +: 8];
    else if (o == 8) r = m_cur[m_bsel*8 +: 8];
    return r;
  endfunction

  function automatic string reg_tag(input logic [15:0] a);
    int o;
    o = int'(a - BASE);
    if (o == 0) return "R2";
    if (o >= 1 && o <= 4) return "R3";
    if (o == 8) return "R5";
    if (o == 7) return "R6";
    return "R4";
  endfunction

  task automatic tick(input logic [15:0] a, input logic w, input logic [7:0] d);
    logic [7:0] e;
    logic       ei;
    @(negedge clk);
    irq_in = in_reg;
    bus_addr = a; bus_wr = w; bus_wdata = d;
    #2;
    e  = exp_read(a);
    ei = |m_pend;
    n_vec++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s (phase %s) addr=%h rdata actual=%h expected=%h",
               reg_tag(a), phase, a, bus_rdata, e);
    end
    n_vec++;
    if (irq_out !== ei) begin
      n_bad++;
      $display("FAIL R11 (phase %s) irq_out actual=%b expected=%b", phase, irq_out, ei);
    end
  endtask

  task automatic rd(input int o);            tick(BASE + 16'(o), 1'b0, 8'h00); endtask
  task automatic wr(input int o, input logic [7:0] d); tick(BASE + 16'(o), 1'b1, d); endtask

  task automatic sweep();
    for (int o = 0; o < 10; o++) rd(o);
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep();
    // masked after reset: toggling a line must set nothing
    in_reg[40] = 1'b1; repeat (4) rd(6);
    wr(5, 8'd5); repeat (3) rd(6); rd(8);
    in_reg[40] = 1'b0; repeat (3) rd(8);

    phase = "R7";  // block 0 line 3 rising only
    wr(5, 8'd0); wr(7, 8'hB2);
    in_reg[3] = 1'b1; rd(6); rd(6); rd(6); rd(0); rd(1);
    in_reg[3] = 1'b0; repeat (3) rd(6);
    wr(7, 8'hBA); rd(6);
    // block 9 line 5 falling only
    wr(5, 8'd9); wr(7, 8'hD4);
    in_reg[77] = 1'b1; repeat (4) rd(6);
    in_reg[77] = 1'b0; repeat (3) rd(6); rd(0); rd(2);
    // block 4 line 1 both edges
    wr(5, 8'd4); wr(7, 8'h90);
    in_reg[33] = 1'b1; repeat (3) rd(6); wr(7, 8'h98); rd(6);
    in_reg[33] = 1'b0; repeat (3) rd(6);

    phase = "R8";  // block 31 line 7 high level
    wr(5, 8'd31); in_reg[255] = 1'b1; repeat (3) rd(8);
    wr(7, 8'hF3); rd(6); rd(0); rd(4);
    wr(7, 8'hFB); rd(6); rd(6);
    in_reg[255] = 1'b0; repeat (3) rd(6); wr(7, 8'hFB); rd(6); rd(6);
    // block 17 line 0 low level
    wr(5, 8'd17); wr(7, 8'h85); rd(6); rd(3);

    phase = "R6";  // guarded write ignored
    wr(7, 8'h0F); rd(6); rd(6);
    wr(5, 8'd31); wr(7, 8'h73); in_reg[255] = 1'b1; repeat (4) rd(6);
    wr(5, 8'd40); rd(5);

    phase = "R10"; // mask-and-acknowledge, then mask keeps latch quiet
    wr(5, 8'd17); wr(7, 8'h8E); rd(6); rd(6); rd(0);
    wr(5, 8'd9); wr(7, 8'hD2); in_reg[77] = 1'b1; repeat (3) rd(6);
    wr(7, 8'hD6); in_reg[77] = 1'b0; repeat (4) rd(6);
    wr(7, 8'hDE); rd(6);

    phase = "R9";  // clear collides with a detected edge
    wr(5, 8'd2); wr(7, 8'h82);
    in_reg[16] = 1'b1; rd(6); rd(6); wr(7, 8'h8A); rd(6); rd(6);
    in_reg[16] = 1'b0; repeat (3) rd(6);

    phase = "R3";  // random traffic
    for (int t = 0; t < 3000; t++) begin
      int op;
      for (int f = 0; f < 4; f++) in_reg[$urandom_range(NI-1)] ^= 1'b1;
      op = $urandom_range(15);
      if (op < 3) wr(5, 8'($urandom_range(40)));
      else if (op < 6) wr(7, 8'($urandom_range(255)));
      else rd($urandom_range(10));
    end
    sweep();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule